// File: doc/BRIEF.md
# Indexed Calendar Clock with Periodic Tick

This block keeps a calendar time of day and gives software byte access to it through two ports that share one bus: an index port and a data port. A write to the index port chooses one internal register. Each later data-port read or write goes to that register until the index is written again. The time fields are seconds, minutes, hours, weekday, day of month, month and year. All of them are plain binary, and hours use the 24-hour form. Three further indices return fixed status and control images.

A free-running prescaler raises a one-cycle periodic interrupt every `TICK_CYCLES` clock cycles. A divider counts these interrupts. On every 1024th interrupt the seconds field advances by one and wraps from 59 to 0. In that same cycle the status image shows an update-in-progress flag. The month is held zero-based inside the block and shown one-based at the port. The year is held as an internal value and shown at the port with a fixed base of 52 subtracted.

Top module: `rtcx_top`

## Requirements
- R1: A write with `bus_port`=0 stores `bus_wdata` as the register index. Data-port accesses (`bus_port`=1) read or write the register that index selects. The index changes only on an index-port write.
- R2: The data port reads and writes plain binary values at these indices: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day of month 0x07. A read shows the value that was written.
- R3: Index 0x08 is the month. It is shown one-based: writing 12 reads back 12, while the block stores 11 inside.
- R4: Index 0x09 is the year. It reads as the internal year minus 52, and a write stores the written value plus 52 (8-bit wrap).
- R5: Index 0x0A reads 0x26 ORed with an update-in-progress flag in bit 7. The flag is high only in the cycle in which the seconds field is about to change, so the read is 0xA6 in that cycle.
- R6: Index 0x0B always reads 0x46 and index 0x0C always reads 0x00. Writes to 0x0A, 0x0B and 0x0C have no effect.
- R7: A data-port read or write while the index is 0x0D, or any index not named in R2–R6, raises `bus_err` for exactly one cycle, in the cycle after the access. The data port reads 0x00 at such an index, and a write there changes no field.
- R8: `tick_irq` is a one-cycle pulse that repeats every `TICK_CYCLES` cycles. The first pulse comes in the `TICK_CYCLES`-th cycle after reset is released.
- R9: The seconds field advances by one on every 1024th `tick_irq` pulse counted from reset and goes from 59 to 0. A write to the seconds field does not restart this count.
- R10: If a seconds write and a seconds advance fall in the same cycle, the written value is kept.
- R11: Synchronous reset loads the time fields from parameters (with the defaults these read 10, 20, 13, 3, 15, month 6, year 53), sets the index to 0x00, and clears the prescaler, the divider and `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the port chosen by `bus_port` |
| bus_rd | input | 1 | Read strobe for the port chosen by `bus_port` |
| bus_port | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Image of the register the index selects |
| bus_err | output | 1 | One-cycle flag after a data access to an invalid index |
| tick_irq | output | 1 | Periodic interrupt pulse |

## Verification
If the prescaler or divider holds a wrong count, the error shows at the ports in two ways. The `tick_irq` spacing is off within one period. The seconds advance and the 0xA6 status image then land on a pulse other than the 1024th. If a time field holds a wrong value, it shows on the next data read of that index. Mistakes in the month or year conversion show at once when a written value is read back. If the index register is corrupted, the very next read returns a different register's image, and `bus_err` goes wrong one cycle after the next data access.

// File: rtl/rtcx_pkg.sv
`timescale 1ns/1ps
package rtcx_pkg;

    localparam int DW = 8;

    // register indices decoded by software
    localparam logic [DW-1:0] IX_SEC  = 8'h00;
    localparam logic [DW-1:0] IX_MIN  = 8'h02;
    localparam logic [DW-1:0] IX_HOUR = 8'h04;
    localparam logic [DW-1:0] IX_WDAY = 8'h06;
    localparam logic [DW-1:0] IX_MDAY = 8'h07;
    localparam logic [DW-1:0] IX_MON  = 8'h08;
    localparam logic [DW-1:0] IX_YEAR = 8'h09;
    localparam logic [DW-1:0] IX_STA  = 8'h0A;
    localparam logic [DW-1:0] IX_CTB  = 8'h0B;
    localparam logic [DW-1:0] IX_CTC  = 8'h0C;

    localparam logic [DW-1:0] STA_BASE  = 8'h26;
    localparam logic [DW-1:0] CTB_IMAGE = 8'h46;
    localparam logic [DW-1:0] CTC_IMAGE = 8'h00;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] wday;
        logic [DW-1:0] mday;
        logic [DW-1:0] mon0;   // zero-based month
        logic [DW-1:0] yr_int; // internal year
    } cal_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [DW-1:0] data;
    } data_acc_t;

    function automatic logic ix_known(input logic [DW-1:0] ix);
        case (ix)
            IX_SEC, IX_MIN, IX_HOUR, IX_WDAY, IX_MDAY,
            IX_MON, IX_YEAR, IX_STA, IX_CTB, IX_CTC: ix_known = 1'b1;
            default:                                 ix_known = 1'b0;
        endcase
    endfunction

    function automatic logic [DW-1:0] sec_next(input logic [DW-1:0] s);
        sec_next = (s >= 8'd59) ? 8'd0 : s + 8'd1;
    endfunction

endpackage

// File: rtl/rtcx_tick.sv
`timescale 1ns/1ps
module rtcx_tick #(
    parameter int TICK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_CYCLES - 1);

    logic [W-1:0] pre_q;
    logic         tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            pre_q  <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
            tick_q <= (pre_q == LAST);
        end
    end

    assign tick_o = tick_q;

    generate
        if (TICK_CYCLES > 1) begin : g_iso
            // R8: pulses are single cycle
            p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
                tick_q |=> !tick_q);
        end
    endgenerate
endmodule

// File: rtl/rtcx_div.sv
`timescale 1ns/1ps
module rtcx_div #(
    parameter int DIV_COUNT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic wrap_o
);
    localparam int W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [W-1:0] LAST = W'(DIV_COUNT - 1);

    logic [W-1:0] cnt_q;

    assign wrap_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R9: the count moves only on a tick
    p_div_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtcx_calregs.sv
`timescale 1ns/1ps
module rtcx_calregs
    import rtcx_pkg::*;
#(
    parameter int INIT_SEC   = 10,
    parameter int INIT_MIN   = 20,
    parameter int INIT_HOUR  = 13,
    parameter int INIT_WDAY  = 3,
    parameter int INIT_MDAY  = 15,
    parameter int INIT_MONTH = 6,
    parameter int INIT_YEAR  = 53,
    parameter int YEAR_BASE  = 52
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ix,
    input  data_acc_t     acc,
    input  logic          adv,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sec_o
);
    localparam logic [DW-1:0] YB = DW'(YEAR_BASE);

    cal_t cal_q;
    logic wr_sec;

    assign wr_sec = acc.wr && (ix == IX_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q.sec    <= DW'(INIT_SEC);
            cal_q.min    <= DW'(INIT_MIN);
            cal_q.hour   <= DW'(INIT_HOUR);
            cal_q.wday   <= DW'(INIT_WDAY);
            cal_q.mday   <= DW'(INIT_MDAY);
            cal_q.mon0   <= DW'(INIT_MONTH - 1);
            cal_q.yr_int <= DW'(INIT_YEAR + YEAR_BASE);
        end else begin
            if (wr_sec)
                cal_q.sec <= acc.data;
            else if (adv)
                cal_q.sec <= sec_next(cal_q.sec);
            if (acc.wr) begin
                case (ix)
                    IX_MIN:  cal_q.min    <= acc.data;
                    IX_HOUR: cal_q.hour   <= acc.data;
                    IX_WDAY: cal_q.wday   <= acc.data;
                    IX_MDAY: cal_q.mday   <= acc.data;
                    IX_MON:  cal_q.mon0   <= acc.data - 8'd1;
                    IX_YEAR: cal_q.yr_int <= acc.data + YB;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (ix)
            IX_SEC:  rdata = cal_q.sec;
            IX_MIN:  rdata = cal_q.min;
            IX_HOUR: rdata = cal_q.hour;
            IX_WDAY: rdata = cal_q.wday;
            IX_MDAY: rdata = cal_q.mday;
            IX_MON:  rdata = cal_q.mon0 + 8'd1;
            IX_YEAR: rdata = cal_q.yr_int - YB;
            IX_STA:  rdata = {adv, 7'h00} | STA_BASE;
            IX_CTB:  rdata = CTB_IMAGE;
            IX_CTC:  rdata = CTC_IMAGE;
            default: rdata = 8'h00;
        endcase
    end

    assign sec_o = cal_q.sec;

    // R10: a seconds write beats the advance
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_sec |=> cal_q.sec == $past(acc.data));
    // R9: an advance without a write moves seconds on by one modulo 60
    p_sec_adv_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_sec && cal_q.sec < 8'd59) |=> cal_q.sec == $past(cal_q.sec) + 8'd1);
    // R3: month written reads back unchanged
    p_month_rt_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && ix == IX_MON) |=> cal_q.mon0 == $past(acc.data) - 8'd1);
endmodule

// File: rtl/rtcx_top.sv
`timescale 1ns/1ps
module rtcx_top
    import rtcx_pkg::*;
#(
    parameter int TICK_CYCLES = 8,
    parameter int DIV_COUNT   = 1024,
    parameter int INIT_SEC    = 10,
    parameter int INIT_MIN    = 20,
    parameter int INIT_HOUR   = 13,
    parameter int INIT_WDAY   = 3,
    parameter int INIT_MDAY   = 15,
    parameter int INIT_MONTH  = 6,
    parameter int INIT_YEAR   = 53,
    parameter int YEAR_BASE   = 52
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_err,
    output logic       tick_irq
);
    logic [DW-1:0] ix_q;
    logic          err_q;
    logic          tick;
    logic          wrap;
    data_acc_t     acc;
    logic [DW-1:0] sec_w;

    assign acc.wr   = bus_wr && bus_port;
    assign acc.rd   = bus_rd && bus_port;
    assign acc.data = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ix_q  <= IX_SEC;
            err_q <= 1'b0;
        end else begin
            if (bus_wr && !bus_port)
                ix_q <= bus_wdata;
            err_q <= (acc.wr || acc.rd) && !ix_known(ix_q);
        end
    end

    rtcx_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    rtcx_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk(clk), .rst(rst), .tick_i(tick), .wrap_o(wrap)
    );

    rtcx_calregs #(
        .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
        .INIT_WDAY(INIT_WDAY), .INIT_MDAY(INIT_MDAY), .INIT_MONTH(INIT_MONTH),
        .INIT_YEAR(INIT_YEAR), .YEAR_BASE(YEAR_BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .ix(ix_q), .acc(acc), .adv(wrap),
        .rdata(bus_rdata), .sec_o(sec_w)
    );

    assign bus_err  = err_q;
    assign tick_irq = tick;

    // R1: the index holds unless the index port is written
    p_index_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_port) |=> $stable(ix_q));
    // R7: an error flag always follows a data access
    p_err_source_r7: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(acc.wr || acc.rd));
    // R9: seconds never change without an advance or a write
    p_sec_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(wrap || (acc.wr && ix_q == IX_SEC)) |=> $stable(sec_w));
endmodule

// File: tb/rtcx_top_tb_top.sv
`timescale 1ns/1ps
module rtcx_top_tb_top;
    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic       tick_irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic last_tick = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtcx_top #(.TICK_CYCLES(N)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .tick_irq(tick_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        last_tick = tick_irq;
        if (tick_irq) pulses++;
    endtask

    task automatic set_ix(input logic [7:0] v);
        bus_wr = 1'b1; bus_port = 1'b0; bus_wdata = v;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic put(input logic [7:0] v);
        bus_wr = 1'b1; bus_port = 1'b1; bus_wdata = v;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic read_at(input logic [7:0] ix, output int v);
        set_ix(ix);
        v = bus_rdata;
    endtask

    task automatic wait_wrap();
        int guard = 0;
        do begin
            step();
            guard++;
        end while (!(last_tick && (pulses % 1024 == 0)) && guard < 5000);
    endtask

    task automatic t_tick_r8();
        int gap;
        chk("R11 err after reset", bus_err, 0);
        chk("R11 index 0 after reset", bus_rdata, 10);
        for (int k = 1; k <= N; k++) begin
            step();
            if (k < N) chk("R8 no early pulse", tick_irq, 0);
        end
        chk("R8 first pulse", tick_irq, 1);
        for (int p = 0; p < 3; p++) begin
            gap = 0;
            do begin step(); gap++; end while (!tick_irq && gap < 10);
            chk("R8 pulse spacing", gap, N);
        end
    endtask

    task automatic t_reset_r11();
        int v;
        read_at(8'h00, v); chk("R11 sec", v, 10);
        read_at(8'h02, v); chk("R11 min", v, 20);
        read_at(8'h04, v); chk("R11 hour", v, 13);
        read_at(8'h06, v); chk("R11 wday", v, 3);
        read_at(8'h07, v); chk("R11 mday", v, 15);
        read_at(8'h08, v); chk("R11 month", v, 6);
        read_at(8'h09, v); chk("R4 year reset image", v, 53);
    endtask

    task automatic t_index_r1_r2();
        int v;
        set_ix(8'h02); put(8'd45); chk("R2 minutes", bus_rdata, 45);
        chk("R1 index kept after data write", bus_rdata, 45);
        set_ix(8'h04); put(8'd23); chk("R2 hours", bus_rdata, 23);
        set_ix(8'h06); put(8'd6);  chk("R2 weekday", bus_rdata, 6);
        set_ix(8'h07); put(8'd31); chk("R2 mday", bus_rdata, 31);
        read_at(8'h02, v); chk("R1 reselect minutes", v, 45);
    endtask

    task automatic t_month_r3();
        set_ix(8'h08);
        put(8'd12); chk("R3 month 12", bus_rdata, 12);
        put(8'd1);  chk("R3 month 1", bus_rdata, 1);
    endtask

    task automatic t_year_r4();
        set_ix(8'h09);
        put(8'd30);  chk("R4 year 30", bus_rdata, 30);
        put(8'd200); chk("R4 year 200 wrap", bus_rdata, 200);
    endtask

    task automatic t_consts_r6();
        int exp;
        set_ix(8'h0B); chk("R6 reg B", bus_rdata, 8'h46);
        put(8'hFF);    chk("R6 write B ignored", bus_rdata, 8'h46);
        set_ix(8'h0C); chk("R6 reg C", bus_rdata, 0);
        put(8'h5A);    chk("R6 write C ignored", bus_rdata, 0);
        set_ix(8'h0A); put(8'h00);
        exp = (last_tick && pulses % 1024 == 0) ? 8'hA6 : 8'h26;
        chk("R6 write A ignored R5 image", bus_rdata, exp);
    endtask

    task automatic t_err_r7();
        int v;
        set_ix(8'h0D);
        chk("R7 reg D reads zero", bus_rdata, 0);
        bus_rd = 1'b1; bus_port = 1'b1; step(); bus_rd = 1'b0;
        chk("R7 err after D read", bus_err, 1);
        step();
        chk("R7 err one cycle", bus_err, 0);
        set_ix(8'h05);
        put(8'h11);
        chk("R7 err after unknown write", bus_err, 1);
        chk("R7 unknown reads zero", bus_rdata, 0);
        read_at(8'h02, v); chk("R7 minutes untouched", v, 45);
        read_at(8'h04, v); chk("R7 hours untouched", v, 23);
        set_ix(8'h0B);
        bus_rd = 1'b1; bus_port = 1'b1; step(); bus_rd = 1'b0;
        chk("R7 no err for valid index", bus_err, 0);
    endtask

    task automatic t_second_r5_r9();
        int s0, v;
        read_at(8'h00, s0);
        set_ix(8'h0A);
        chk("R5 status idle", bus_rdata, 8'h26);
        wait_wrap();
        chk("R5 update flag on 1024th pulse", bus_rdata, 8'hA6);
        step();
        chk("R5 flag drops", bus_rdata, 8'h26);
        read_at(8'h00, v);
        chk("R9 seconds advance", v, (s0 + 1) % 60);
    endtask

    task automatic t_roll_r9();
        int v;
        set_ix(8'h00);
        put(8'd59);
        chk("R9 write 59", bus_rdata, 59);
        wait_wrap();
        step();
        chk("R9 59 wraps to 0", bus_rdata, 0);
    endtask

    task automatic t_prio_r10();
        set_ix(8'h00);
        wait_wrap();
        put(8'd42);
        chk("R10 write wins", bus_rdata, 42);
        wait_wrap();
        step();
        chk("R10 next advance", bus_rdata, 43);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_tick_r8();
        t_reset_r11();
        t_index_r1_r2();
        t_month_r3();
        t_year_r4();
        t_consts_r6();
        t_err_r7();
        t_second_r5_r9();
        t_roll_r9();
        t_prio_r10();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule